// File: doc/BRIEF.md
# SDRAM Timing Parameter Encoder

This block turns a set of SDRAM device timings, given in nanoseconds, into the two configuration words an SDRAM controller needs: a packed timing word and a refresh-interval word. After a start pulse it captures the bus clock frequency, the CAS latency, five device delays, the row-address width and the refresh period. A single sequential divider then works out the bus clock period in tenths of a nanosecond, the clock count of each delay, and the refresh count. Each count is clamped to the legal range of its field and packed into place.

When the caller has no device timings to offer, it clears `use_cfg`. The block then skips the arithmetic and returns one of two fixed word pairs, chosen by whether the bus frequency is above 100 MHz. In either mode a one-cycle `done` pulse marks fresh words. Both words then hold until the next completion.

Top module: `sdr_timing_enc`

## Requirements
- R1: During and right after reset, `busy` and `done` are low and both output words are zero.
- R2: The CAS code sits in timing-word bits 24:23. A latency below 2 gives code 1, a latency above 4 gives code 3, and any other latency L gives code L-1.
- R3: A delay of N ns becomes floor(N*10 / P) + 1 clocks. P is floor(10^9 / floor(freq_hz/10)), the period in tenths of a nanosecond.
- R4: The precharge delay (bits 19:18), the command-to-precharge delay (bits 17:16) and the RAS-to-CAS delay (bits 1:0) each encode a count C of 2..4 as C-1. Any other count encodes as 3.
- R5: The data-to-float delay (bits 15:14) encodes a count C of 2..4 as C-1. Any other count encodes as 1.
- R6: The refresh-to-activate delay (bits 4:2) encodes a count C of 4..10 as C-4. Any other count encodes as 6.
- R7: The refresh count is floor(floor(refresh_ms*10^6 / 2^rows) * floor(freq_hz/1000) / 10^6). Bits 13:3 of that count go to refresh-word bits 29:19, and every other refresh-word bit is zero.
- R8: With `use_cfg` low, a start gives 0x01074015 / 0x07F00000 when freq_hz > 100,000,000, and 0x0086400D / 0x05F00000 otherwise. `done` rises in the cycle after the start.
- R9: Each result is marked by a `done` pulse one cycle long. `busy` is high from the cycle after a computed-mode start until the result appears. Between completions the words do not change.
- R10: A start while `busy` is high is ignored. All inputs are captured at the accepted start, so later input changes do not affect the result.
- R11: A start in the cycle that `done` is high is accepted, and a new run begins.
- R12: Timing-word bits outside the six fields are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a new computation |
| use_cfg | input | 1 | 1: compute from timings; 0: fixed defaults |
| bus_freq_hz | input | FREQ_W | Bus clock frequency in Hz |
| cas_lat | input | 3 | CAS latency in clocks |
| t_pta_ns | input | NS_W | Precharge delay, ns |
| t_ctp_ns | input | NS_W | Command-to-precharge delay, ns |
| t_ldf_ns | input | NS_W | Data-to-float delay, ns |
| t_rfta_ns | input | NS_W | Refresh-to-activate delay, ns |
| t_rcd_ns | input | NS_W | RAS-to-CAS delay, ns |
| row_bits | input | ROW_W | Row address width in bits |
| refresh_ms | input | REF_W | Refresh period in ms |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: words valid |
| timing_word | output | 32 | Packed timing word |
| refresh_word | output | 32 | Refresh interval word |

## Verification
There is one place where two actions share a cycle. A completion can be reported while a new start is accepted, because `done` is high in the same cycle in which the sequencer is back in its idle phase. The bench provokes this by raising `start` with `use_cfg` low in exactly the cycle where it sees a computed result's `done`. It then expects `done` to stay high for one more cycle and to carry the default words. The bench also raises `start` in the middle of a computed run, with different inputs. It expects the original result, reported only once.

// File: rtl/sdr_tim_pkg.sv
package sdr_tim_pkg;

    localparam int NFIELD = 5;
    localparam int F_PTA  = 0;
    localparam int F_CTP  = 1;
    localparam int F_LDF  = 2;
    localparam int F_RFTA = 3;
    localparam int F_RCD  = 4;

    // per-field legal clock range, offset, fallback code, position, width
    localparam int unsigned FLD_LO  [NFIELD] = '{2, 2, 2, 4, 2};
    localparam int unsigned FLD_HI  [NFIELD] = '{4, 4, 4, 10, 4};
    localparam int unsigned FLD_OFF [NFIELD] = '{1, 1, 1, 4, 1};
    localparam int unsigned FLD_FB  [NFIELD] = '{3, 3, 1, 6, 3};
    localparam int unsigned FLD_LSB [NFIELD] = '{18, 16, 14, 2, 0};
    localparam int unsigned FLD_WID [NFIELD] = '{2, 2, 2, 3, 2};

    localparam int unsigned CAS_LSB = 23;
    localparam int unsigned CAS_W   = 2;

    typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT, PH_PACK} phase_e;

    // division schedule
    localparam logic [3:0] OP_F10 = 4'd0;
    localparam logic [3:0] OP_PER = 4'd1;
    localparam logic [3:0] OP_NS0 = 4'd2;
    localparam logic [3:0] OP_KHZ = 4'd7;
    localparam logic [3:0] OP_REF = 4'd8;

    function automatic logic [31:0] tw_mask();
        logic [31:0] m;
        m = ((32'd1 << CAS_W) - 32'd1) << CAS_LSB;
        for (int i = 0; i < NFIELD; i++)
            m |= ((32'd1 << FLD_WID[i]) - 32'd1) << FLD_LSB[i];
        return m;
    endfunction

    localparam logic [31:0] TW_MASK = tw_mask();

endpackage

// File: rtl/sdr_seq_div.sv
module sdr_seq_div #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic          done;
    } dv_t;

    dv_t dv_d, dv_q;
    logic [W:0] trial;

    // restoring division, one quotient bit per cycle; divisor held by caller
    always_comb begin
        dv_d      = dv_q;
        dv_d.done = 1'b0;
        trial     = {dv_q.rem, dv_q.quo[W-1]};
        if (dv_q.busy) begin
            if (trial >= {1'b0, divisor}) begin
                dv_d.rem = W'(trial - {1'b0, divisor});
                dv_d.quo = {dv_q.quo[W-2:0], 1'b1};
            end else begin
                dv_d.rem = trial[W-1:0];
                dv_d.quo = {dv_q.quo[W-2:0], 1'b0};
            end
            dv_d.cnt = dv_q.cnt - CW'(1);
            if (dv_q.cnt == CW'(1)) begin
                dv_d.busy = 1'b0;
                dv_d.done = 1'b1;
            end
        end else if (start) begin
            dv_d.busy = 1'b1;
            dv_d.cnt  = CW'(W);
            dv_d.rem  = '0;
            dv_d.quo  = dividend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign done     = dv_q.done;
    assign quotient = dv_q.quo;

endmodule

// File: rtl/sdr_fld_enc.sv
module sdr_fld_enc #(
    parameter int          CW  = 64,
    parameter int unsigned LO  = 2,
    parameter int unsigned HI  = 4,
    parameter int unsigned OFF = 1,
    parameter int unsigned FB  = 3,
    parameter int          OW  = 2
) (
    input  logic [CW-1:0] count,
    output logic [OW-1:0] code
);
    logic in_range;

    always_comb begin
        in_range = (count >= CW'(LO)) && (count <= CW'(HI));
        code     = in_range ? OW'(count - CW'(OFF)) : OW'(FB);
    end

endmodule

// File: rtl/sdr_timing_enc.sv
module sdr_timing_enc
    import sdr_tim_pkg::*;
#(
    parameter int          FREQ_W     = 32,
    parameter int          NS_W       = 10,
    parameter int          ROW_W      = 5,
    parameter int          REF_W      = 8,
    parameter int          DW         = 64,
    parameter int unsigned FAST_HZ    = 100_000_000,
    parameter logic [31:0] DEF_TW_HI  = 32'h0107_4015,
    parameter logic [31:0] DEF_RW_HI  = 32'h07F0_0000,
    parameter logic [31:0] DEF_TW_LO  = 32'h0086_400D,
    parameter logic [31:0] DEF_RW_LO  = 32'h05F0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              use_cfg,
    input  logic [FREQ_W-1:0] bus_freq_hz,
    input  logic [2:0]        cas_lat,
    input  logic [NS_W-1:0]   t_pta_ns,
    input  logic [NS_W-1:0]   t_ctp_ns,
    input  logic [NS_W-1:0]   t_ldf_ns,
    input  logic [NS_W-1:0]   t_rfta_ns,
    input  logic [NS_W-1:0]   t_rcd_ns,
    input  logic [ROW_W-1:0]  row_bits,
    input  logic [REF_W-1:0]  refresh_ms,
    output logic              busy,
    output logic              done,
    output logic [31:0]       timing_word,
    output logic [31:0]       refresh_word
);
    localparam logic [DW-1:0] K_TEN  = DW'(10);
    localparam logic [DW-1:0] K_KILO = DW'(1000);
    localparam logic [DW-1:0] K_MEGA = DW'(1_000_000);
    localparam logic [DW-1:0] K_GIGA = DW'(1_000_000_000);

    typedef struct packed {
        phase_e                       phase;
        logic [3:0]                   op;
        logic [FREQ_W-1:0]            freq;
        logic [2:0]                   cas;
        logic [NFIELD-1:0][NS_W-1:0]  ns;
        logic [ROW_W-1:0]             rows;
        logic [REF_W-1:0]             ref_ms;
        logic [DW-1:0]                f10;
        logic [DW-1:0]                p10;
        logic [DW-1:0]                khz;
        logic [DW-1:0]                rcount;
        logic [NFIELD-1:0][DW-1:0]    cnt;
        logic [31:0]                  tword;
        logic [31:0]                  rword;
        logic                         done;
    } st_t;

    st_t st_d, st_q;

    logic          div_start, div_done;
    logic [DW-1:0] div_dvd, div_dvs, div_quo;
    logic [2:0]    fidx;
    logic [DW-1:0] row_quot;
    logic [1:0]    cas_code;
    logic [31:0]   fld_bits [NFIELD];
    logic [31:0]   tw_packed;

    assign fidx = 3'(st_q.op - OP_NS0);

    // operand selection for the current division step
    always_comb begin
        row_quot = (DW'(st_q.ref_ms) * K_MEGA) >> st_q.rows;
        div_dvd  = '0;
        div_dvs  = K_TEN;
        case (st_q.op)
            OP_F10: begin
                div_dvd = DW'(st_q.freq);
                div_dvs = K_TEN;
            end
            OP_PER: begin
                div_dvd = K_GIGA;
                div_dvs = st_q.f10;
            end
            OP_KHZ: begin
                div_dvd = DW'(st_q.freq);
                div_dvs = K_KILO;
            end
            OP_REF: begin
                div_dvd = row_quot * st_q.khz;
                div_dvs = K_MEGA;
            end
            default: begin
                div_dvd = DW'(st_q.ns[fidx]) * K_TEN + st_q.p10;
                div_dvs = st_q.p10;
            end
        endcase
    end

    sdr_seq_div #(.W(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_dvd),
        .divisor  (div_dvs),
        .done     (div_done),
        .quotient (div_quo)
    );

    // field clamping and placement
    for (genvar g = 0; g < NFIELD; g++) begin : g_fld
        logic [FLD_WID[g]-1:0] code;
        sdr_fld_enc #(
            .CW  (DW),
            .LO  (FLD_LO[g]),
            .HI  (FLD_HI[g]),
            .OFF (FLD_OFF[g]),
            .FB  (FLD_FB[g]),
            .OW  (FLD_WID[g])
        ) u_enc (
            .count (st_q.cnt[g]),
            .code  (code)
        );
        assign fld_bits[g] = 32'(code) << FLD_LSB[g];
    end

    always_comb begin
        if (st_q.cas < 3'd2)      cas_code = 2'd1;
        else if (st_q.cas > 3'd4) cas_code = 2'd3;
        else                      cas_code = 2'(st_q.cas - 3'd1);
        tw_packed = 32'(cas_code) << CAS_LSB;
        for (int i = 0; i < NFIELD; i++)
            tw_packed |= fld_bits[i];
    end

    // sequencer
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        div_start = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.freq        = bus_freq_hz;
                    st_d.cas         = cas_lat;
                    st_d.ns[F_PTA]   = t_pta_ns;
                    st_d.ns[F_CTP]   = t_ctp_ns;
                    st_d.ns[F_LDF]   = t_ldf_ns;
                    st_d.ns[F_RFTA]  = t_rfta_ns;
                    st_d.ns[F_RCD]   = t_rcd_ns;
                    st_d.rows        = row_bits;
                    st_d.ref_ms      = refresh_ms;
                    if (use_cfg) begin
                        st_d.phase = PH_ISSUE;
                        st_d.op    = OP_F10;
                    end else begin
                        if (bus_freq_hz > FREQ_W'(FAST_HZ)) begin
                            st_d.tword = DEF_TW_HI;
                            st_d.rword = DEF_RW_HI;
                        end else begin
                            st_d.tword = DEF_TW_LO;
                            st_d.rword = DEF_RW_LO;
                        end
                        st_d.done = 1'b1;
                    end
                end
            end
            PH_ISSUE: begin
                div_start  = 1'b1;
                st_d.phase = PH_WAIT;
            end
            PH_WAIT: begin
                if (div_done) begin
                    case (st_q.op)
                        OP_F10:  st_d.f10    = div_quo;
                        OP_PER:  st_d.p10    = div_quo;
                        OP_KHZ:  st_d.khz    = div_quo;
                        OP_REF:  st_d.rcount = div_quo;
                        default: st_d.cnt[fidx] = div_quo;
                    endcase
                    if (st_q.op == OP_REF) begin
                        st_d.phase = PH_PACK;
                    end else begin
                        st_d.op    = st_q.op + 4'd1;
                        st_d.phase = PH_ISSUE;
                    end
                end
            end
            default: begin
                st_d.tword = tw_packed;
                st_d.rword = {2'b00, st_q.rcount[13:3], 19'd0};
                st_d.done  = 1'b1;
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy         = (st_q.phase != PH_IDLE);
    assign done         = st_q.done;
    assign timing_word  = st_q.tword;
    assign refresh_word = st_q.rword;

endmodule

// File: rtl/sdr_timing_enc_chk.sv
module sdr_timing_enc_chk
    import sdr_tim_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        use_cfg,
    input logic        busy,
    input logic        done,
    input logic [31:0] timing_word,
    input logic [31:0] refresh_word
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done || $past(start)));                                   // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                     // R9

    AST_WORDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(timing_word) && $stable(refresh_word)));          // R9

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && use_cfg && !busy) |=> busy);                               // R9

    AST_DEFAULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !use_cfg && !busy) |=> (done && !busy));                   // R8

    AST_CAS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (timing_word[CAS_LSB +: CAS_W] != '0));                     // R2

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((timing_word & ~TW_MASK) == 32'd0));                       // R12

    AST_REFRESH_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (refresh_word[18:0] == 19'd0 && refresh_word[31:30] == 2'd0)); // R7

endmodule

bind sdr_timing_enc sdr_timing_enc_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .use_cfg      (use_cfg),
    .busy         (busy),
    .done         (done),
    .timing_word  (timing_word),
    .refresh_word (refresh_word)
);

// File: tb/sdr_timing_enc_tb.sv
module sdr_timing_enc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        use_cfg = 1'b0;
    logic [31:0] bus_freq_hz = '0;
    logic [2:0]  cas_lat = '0;
    logic [9:0]  t_pta_ns = '0, t_ctp_ns = '0, t_ldf_ns = '0, t_rfta_ns = '0, t_rcd_ns = '0;
    logic [4:0]  row_bits = '0;
    logic [7:0]  refresh_ms = '0;
    logic        busy, done;
    logic [31:0] timing_word, refresh_word;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sdr_timing_enc u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .use_cfg(use_cfg),
        .bus_freq_hz(bus_freq_hz), .cas_lat(cas_lat),
        .t_pta_ns(t_pta_ns), .t_ctp_ns(t_ctp_ns), .t_ldf_ns(t_ldf_ns),
        .t_rfta_ns(t_rfta_ns), .t_rcd_ns(t_rcd_ns),
        .row_bits(row_bits), .refresh_ms(refresh_ms),
        .busy(busy), .done(done),
        .timing_word(timing_word), .refresh_word(refresh_word)
    );

    typedef struct packed {
        logic        cfg;
        logic [31:0] freq;
        logic [2:0]  cas;
        logic [9:0]  pta, ctp, ldf, rfta, rcd;
        logic [4:0]  rows;
        logic [7:0]  refms;
        logic [31:0] tw, rw;
    } vec_t;

    // expected words worked out by hand from the requirements
    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 32'd100_000_000, 3'd3, 10'd20, 10'd15, 10'd30, 10'd65,  10'd25, 5'd12, 8'd64, 32'h0109C00E, 32'h06180000},
        '{1'b1, 32'd133_000_000, 3'd1, 10'd0,  10'd50, 10'd5,  10'd2,   10'd30, 5'd13, 8'd64, 32'h008F401B, 32'h04080000},
        '{1'b1, 32'd100_000_000, 3'd6, 10'd39, 10'd10, 10'd40, 10'd99,  10'd9,  5'd12, 8'd16, 32'h018D401B, 32'h01800000},
        '{1'b1, 32'd50_000_000,  3'd4, 10'd60, 10'd20, 10'd45, 10'd60,  10'd40, 5'd12, 8'd64, 32'h018D8002, 32'h03080000},
        '{1'b1, 32'd100_000_000, 3'd2, 10'd19, 10'd29, 10'd19, 10'd100, 10'd35, 5'd13, 8'd64, 32'h0086401B, 32'h03080000},
        '{1'b0, 32'd133_000_000, 3'd0, 10'd0,  10'd0,  10'd0,  10'd0,   10'd0,  5'd0,  8'd0,  32'h01074015, 32'h07F00000},
        '{1'b0, 32'd100_000_000, 3'd0, 10'd0,  10'd0,  10'd0,  10'd0,   10'd0,  5'd0,  8'd0,  32'h0086400D, 32'h05F00000},
        '{1'b0, 32'd100_000_001, 3'd0, 10'd0,  10'd0,  10'd0,  10'd0,   10'd0,  5'd0,  8'd0,  32'h01074015, 32'h07F00000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        use_cfg     = v.cfg;
        bus_freq_hz = v.freq;
        cas_lat     = v.cas;
        t_pta_ns    = v.pta;
        t_ctp_ns    = v.ctp;
        t_ldf_ns    = v.ldf;
        t_rfta_ns   = v.rfta;
        t_rcd_ns    = v.rcd;
        row_bits    = v.rows;
        refresh_ms  = v.refms;
    endtask

    // called at a negedge; returns at the negedge where done is seen
    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy in reset", {31'd0, busy}, 32'd0);
        chk("R1 done in reset", {31'd0, done}, 32'd0);
        chk("R1 timing word in reset", timing_word, 32'd0);
        chk("R1 refresh word in reset", refresh_word, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 timing word after reset", timing_word, 32'd0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (VEC[i].cfg) begin
                chk("R9 busy after start", {31'd0, busy}, 32'd1);
                chk("R9 no early done", {31'd0, done}, 32'd0);
            end else begin
                chk("R8 done in cycle after start", {31'd0, done}, 32'd1);
            end
            wait_done(n);
            // exact compare also covers R12 (unused bits zero)
            if (VEC[i].cfg) begin
                chk("R2 R3 R4 R5 R6 R12 timing word", timing_word, VEC[i].tw);
                chk("R7 refresh word", refresh_word, VEC[i].rw);
            end else begin
                chk("R8 default timing word", timing_word, VEC[i].tw);
                chk("R8 default refresh word", refresh_word, VEC[i].rw);
            end
            @(negedge clk);
            chk("R9 done is one cycle", {31'd0, done}, 32'd0);
            repeat (5) @(negedge clk);
            chk("R9 timing word held", timing_word, VEC[i].tw);
            chk("R9 refresh word held", refresh_word, VEC[i].rw);
        end

        // R10: start mid-run with other inputs is ignored
        drive(VEC[0]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        drive(VEC[6]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drive(VEC[1]);
        chk("R10 no done from ignored start", {31'd0, done}, 32'd0);
        chk("R10 still busy", {31'd0, busy}, 32'd1);
        wait_done(n);
        chk("R10 timing word from captured inputs", timing_word, VEC[0].tw);
        chk("R10 refresh word from captured inputs", refresh_word, VEC[0].rw);
        @(negedge clk);
        chk("R10 single completion", {31'd0, done}, 32'd0);

        // R11: start accepted in the done cycle
        drive(VEC[2]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(n);
        chk("R11 first result timing", timing_word, VEC[2].tw);
        drive(VEC[6]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 second done follows", {31'd0, done}, 32'd1);
        chk("R11 second timing word", timing_word, VEC[6].tw);
        chk("R11 second refresh word", refresh_word, VEC[6].rw);
        @(negedge clk);
        chk("R11 done drops", {31'd0, done}, 32'd0);

        // R1: reset mid-run clears everything
        drive(VEC[3]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 busy cleared by reset", {31'd0, busy}, 32'd0);
        chk("R1 word cleared by reset", timing_word, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        summary();
        $finish;
    end

endmodule